// File: doc/BRIEF.md
# Hardwired Micro-Operation Control Sequencer

This block is the control unit of a small single-accumulator processor, together with the register datapath it steers. It holds an address register, a buffer register, a program counter, an instruction register and one accumulator. A major-cycle register selects fetch, indirect, execute or interrupt entry. A step counter produces the timing steps t1 to t4. Hardwired decode of the major cycle, the step and a one-hot opcode produces the register-transfer controls for each step. One step runs in each clock cycle.

The instruction word is 16 bits. Bits [15:12] hold the opcode, bit 11 is the indirect flag and bits [10:0] hold the address. The block talks to a simple memory. The address comes from the address register and the write data from the buffer register. Read data is returned combinationally in the same cycle as the read strobe, and a write takes effect on the clock edge at which the write strobe is high. The program counter and the accumulator are brought out so that execution can be observed.

Top module: `uop_sequencer`

## Requirements
- R1: While reset is low, and in the first cycle after it, the program counter and accumulator are 0 and both strobes are low. Execution starts in fetch at step t1 and begins at address 0.
- R2: Fetch takes three cycles. Step t1 loads the address register from the PC. Step t2 raises the read strobe at the PC address and increments the PC. Step t3 copies the word read into the instruction register.
- R3: Opcode 0 (add) reads the word at its address in execute step t2 and adds it to the accumulator at the end of step t3. An add takes 6 cycles including fetch.
- R4: When the indirect flag (bit 11) is set, a three-step indirect cycle runs between fetch and execute. It reads the word at the address field and puts its bits [10:0] in place of the address field. Execute then uses that address as if it were direct.
- R5: Opcode 1 (increment and skip) reads in step t2 and increments in step t3. In step t4 it writes the incremented value back to the same address. If that value is zero, the PC is incremented again in the same step, so the next instruction is skipped.
- R6: An increment and skip whose result is nonzero writes the result back and does not skip.
- R7: Opcode 2 (branch and save) writes the return address (the PC after fetch) to its address X in step t2. Execution then continues at X+1.
- R8: An interrupt request high at the last execute step, while interrupts are enabled, starts a three-step interrupt cycle. It writes the PC to save address 0 in step t3 and continues fetching at routine address 1.
- R9: Interrupts are enabled by reset and disabled on entry to the interrupt cycle. After that, a request that stays high has no effect.
- R10: Opcode 15 (halt) freezes the sequencer until reset. After it there are no more strobes, and the PC and accumulator stay constant.
- R11: The read and write strobes are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq | input | 1 | Interrupt request, level sensitive |
| mem_rd | output | 1 | Read strobe |
| mem_wr | output | 1 | Write strobe |
| mem_addr | output | 11 | Memory address (address register) |
| mem_wdata | output | 16 | Write data (buffer register) |
| mem_rdata | input | 16 | Read data, valid in the strobe cycle |
| pc_out | output | 11 | Program counter |
| acc_out | output | 16 | Accumulator |

## Verification
The bench checks the cycle, the address and the data of every bus transaction against a precomputed program trace. A design that merged steps or added a step would shift the cycle numbers. An increment and skip whose result wraps to zero must skip the following halt word. A design that skipped on the wrong value would either halt there or miss the skip. The interrupt request is held high for the whole run. A design that did not clear the enable bit would write to the save address more than once, and one that took the request early or late would write the wrong return PC. An indirect add must use the pointed-to address, and a branch and save must store PC+1 and resume at X+1. Any of these faults shows up as a wrong address or a wrong write value.

// File: rtl/uop_pkg.sv
package uop_pkg;

   typedef enum logic [2:0] {
      MC_FETCH = 3'd0,
      MC_INDIR = 3'd1,
      MC_EXEC  = 3'd2,
      MC_INTR  = 3'd3,
      MC_HALT  = 3'd4
   } major_e;

   typedef struct packed {
      logic mar_pc;
      logic mar_ir;
      logic mar_save;
      logic mbr_mem;
      logic mbr_pc;
      logic mbr_inc;
      logic ir_mbr;
      logic iraddr_mbr;
      logic pc_inc;
      logic pc_ir;
      logic pc_vec;
      logic acc_add;
      logic rd;
      logic wr;
      logic ien_clr;
      logic last;
   } ctl_t;

endpackage

// File: rtl/uop_step_counter.sv
module uop_step_counter #(
   parameter int  NSTEPS      = 4,
   parameter bit  STEP_ONEHOT = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clr,
   input  logic              hold,
   output logic [NSTEPS-1:0] tstep
);
   localparam int CW = (NSTEPS > 1) ? $clog2(NSTEPS) : 1;

   generate
      if (STEP_ONEHOT) begin : g_ring
         logic [NSTEPS-1:0] ring_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)     ring_q <= NSTEPS'(1);
            else if (hold)  ring_q <= ring_q;
            else if (clr)   ring_q <= NSTEPS'(1);
            else            ring_q <= {ring_q[NSTEPS-2:0], ring_q[NSTEPS-1]};
         end
         assign tstep = ring_q;
      end else begin : g_bin
         logic [CW-1:0] cnt_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                         cnt_q <= '0;
            else if (hold)                      cnt_q <= cnt_q;
            else if (clr || cnt_q == CW'(NSTEPS-1)) cnt_q <= '0;
            else                                cnt_q <= cnt_q + 1'b1;
         end
         assign tstep = NSTEPS'(1) << cnt_q;
      end
   endgenerate

endmodule

// File: rtl/uop_decoder.sv
module uop_decoder
   import uop_pkg::*;
#(
   parameter int          OPC_W  = 4,
   parameter int          NSTEPS = 4,
   parameter int unsigned OP_ADD = 0,
   parameter int unsigned OP_ISZ = 1,
   parameter int unsigned OP_BSA = 2,
   parameter int unsigned OP_HLT = 15
) (
   input  major_e            major,
   input  logic [NSTEPS-1:0] tstep,
   input  logic [OPC_W-1:0]  opcode,
   input  logic              ind_next,
   input  logic              mbr_zero,
   input  logic              ien,
   input  logic              irq,
   output ctl_t              ctl,
   output major_e            major_nx
);
   localparam int NOPS = 2 ** OPC_W;

   logic [NOPS-1:0] op_hot;

   generate
      for (genvar i = 0; i < NOPS; i++) begin : g_opdec
         assign op_hot[i] = (opcode == OPC_W'(i));
      end
   endgenerate

   logic is_add, is_isz, is_bsa, is_hlt;
   assign is_add = op_hot[OP_ADD];
   assign is_isz = op_hot[OP_ISZ];
   assign is_bsa = op_hot[OP_BSA];
   assign is_hlt = op_hot[OP_HLT];

   logic t1, t2, t3, t4;
   assign t1 = tstep[0];
   assign t2 = tstep[1];
   assign t3 = tstep[2];
   assign t4 = tstep[3];

   major_e after_exec;
   assign after_exec = (ien && irq) ? MC_INTR : MC_FETCH;

   always_comb begin
      ctl      = '0;
      major_nx = major;
      unique case (major)
         MC_FETCH: begin
            ctl.mar_pc  = t1;
            ctl.rd      = t2;
            ctl.mbr_mem = t2;
            ctl.pc_inc  = t2;
            ctl.ir_mbr  = t3;
            ctl.last    = t3;
            major_nx    = ind_next ? MC_INDIR : MC_EXEC;
         end
         MC_INDIR: begin
            ctl.mar_ir     = t1;
            ctl.rd         = t2;
            ctl.mbr_mem    = t2;
            ctl.iraddr_mbr = t3;
            ctl.last       = t3;
            major_nx       = MC_EXEC;
         end
         MC_EXEC: begin
            if (is_add) begin
               ctl.mar_ir  = t1;
               ctl.rd      = t2;
               ctl.mbr_mem = t2;
               ctl.acc_add = t3;
               ctl.last    = t3;
               major_nx    = after_exec;
            end else if (is_isz) begin
               ctl.mar_ir  = t1;
               ctl.rd      = t2;
               ctl.mbr_mem = t2;
               ctl.mbr_inc = t3;
               ctl.wr      = t4;
               ctl.pc_inc  = t4 && mbr_zero;
               ctl.last    = t4;
               major_nx    = after_exec;
            end else if (is_bsa) begin
               ctl.mar_ir  = t1;
               ctl.mbr_pc  = t1;
               ctl.pc_ir   = t2;
               ctl.wr      = t2;
               ctl.pc_inc  = t3;
               ctl.last    = t3;
               major_nx    = after_exec;
            end else if (is_hlt) begin
               ctl.last    = t1;
               major_nx    = MC_HALT;
            end else begin
               ctl.last    = t1;
               major_nx    = after_exec;
            end
            ctl.ien_clr = ctl.last && (major_nx == MC_INTR);
         end
         MC_INTR: begin
            ctl.mbr_pc   = t1;
            ctl.mar_save = t2;
            ctl.pc_vec   = t2;
            ctl.wr       = t3;
            ctl.last     = t3;
            major_nx     = MC_FETCH;
         end
         default: begin
            major_nx = MC_HALT;
         end
      endcase
   end

endmodule

// File: rtl/uop_datapath.sv
module uop_datapath
   import uop_pkg::*;
#(
   parameter int                WORD_W    = 16,
   parameter int                ADDR_W    = 11,
   parameter logic [ADDR_W-1:0] SAVE_ADDR = '0,
   parameter logic [ADDR_W-1:0] VEC_ADDR  = ADDR_W'(1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  ctl_t              ctl,
   input  logic [WORD_W-1:0] rdata,
   output logic [ADDR_W-1:0] mar,
   output logic [WORD_W-1:0] mbr,
   output logic [WORD_W-1:0] ir,
   output logic [ADDR_W-1:0] pc,
   output logic [WORD_W-1:0] acc
);
   localparam int PAD_W = WORD_W - ADDR_W;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mar <= '0;
         mbr <= '0;
         ir  <= '0;
         pc  <= '0;
         acc <= '0;
      end else begin
         if (ctl.mar_pc)        mar <= pc;
         else if (ctl.mar_ir)   mar <= ir[ADDR_W-1:0];
         else if (ctl.mar_save) mar <= SAVE_ADDR;

         if (ctl.mbr_mem)       mbr <= rdata;
         else if (ctl.mbr_pc)   mbr <= {{PAD_W{1'b0}}, pc};
         else if (ctl.mbr_inc)  mbr <= mbr + 1'b1;

         if (ctl.ir_mbr)          ir <= mbr;
         else if (ctl.iraddr_mbr) ir[ADDR_W-1:0] <= mbr[ADDR_W-1:0];

         if (ctl.pc_inc)        pc <= pc + 1'b1;
         else if (ctl.pc_ir)    pc <= ir[ADDR_W-1:0];
         else if (ctl.pc_vec)   pc <= VEC_ADDR;

         if (ctl.acc_add)       acc <= acc + mbr;
      end
   end

endmodule

// File: rtl/uop_sequencer.sv
module uop_sequencer
   import uop_pkg::*;
#(
   parameter int                WORD_W      = 16,
   parameter int                OPC_W       = 4,
   parameter int                ADDR_W      = 11,
   parameter int                NSTEPS      = 4,
   parameter bit                STEP_ONEHOT = 1'b1,
   parameter logic [ADDR_W-1:0] SAVE_ADDR   = '0,
   parameter logic [ADDR_W-1:0] VEC_ADDR    = ADDR_W'(1),
   parameter int unsigned       OP_ADD      = 0,
   parameter int unsigned       OP_ISZ      = 1,
   parameter int unsigned       OP_BSA      = 2,
   parameter int unsigned       OP_HLT      = 15
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              irq,
   output logic              mem_rd,
   output logic              mem_wr,
   output logic [ADDR_W-1:0] mem_addr,
   output logic [WORD_W-1:0] mem_wdata,
   input  logic [WORD_W-1:0] mem_rdata,
   output logic [ADDR_W-1:0] pc_out,
   output logic [WORD_W-1:0] acc_out
);
   localparam int IND_BIT = ADDR_W;

   generate
      if (OPC_W + 1 + ADDR_W != WORD_W) begin : g_bad_fmt
         $error("word must hold opcode, indirect flag and address exactly");
      end
      if (NSTEPS < 4) begin : g_bad_steps
         $error("at least four timing steps are needed");
      end
      if (OP_ADD >= 2**OPC_W || OP_ISZ >= 2**OPC_W ||
          OP_BSA >= 2**OPC_W || OP_HLT >= 2**OPC_W) begin : g_bad_op
         $error("opcode value does not fit the opcode field");
      end
   endgenerate

   major_e            major_q, major_nx;
   logic              ien_q;
   logic              halted;
   ctl_t              ctl;
   logic [NSTEPS-1:0] tstep;
   logic [ADDR_W-1:0] mar, pc;
   logic [WORD_W-1:0] mbr, ir, acc;

   assign halted = (major_q == MC_HALT);

   uop_step_counter #(
      .NSTEPS      (NSTEPS),
      .STEP_ONEHOT (STEP_ONEHOT)
   ) u_steps (
      .clk   (clk),
      .rst_n (rst_n),
      .clr   (ctl.last),
      .hold  (halted),
      .tstep (tstep)
   );

   uop_decoder #(
      .OPC_W  (OPC_W),
      .NSTEPS (NSTEPS),
      .OP_ADD (OP_ADD),
      .OP_ISZ (OP_ISZ),
      .OP_BSA (OP_BSA),
      .OP_HLT (OP_HLT)
   ) u_dec (
      .major    (major_q),
      .tstep    (tstep),
      .opcode   (ir[WORD_W-1 -: OPC_W]),
      .ind_next (mbr[IND_BIT]),
      .mbr_zero (mbr == '0),
      .ien      (ien_q),
      .irq      (irq),
      .ctl      (ctl),
      .major_nx (major_nx)
   );

   uop_datapath #(
      .WORD_W    (WORD_W),
      .ADDR_W    (ADDR_W),
      .SAVE_ADDR (SAVE_ADDR),
      .VEC_ADDR  (VEC_ADDR)
   ) u_dp (
      .clk   (clk),
      .rst_n (rst_n),
      .ctl   (ctl),
      .rdata (mem_rdata),
      .mar   (mar),
      .mbr   (mbr),
      .ir    (ir),
      .pc    (pc),
      .acc   (acc)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         major_q <= MC_FETCH;
         ien_q   <= 1'b1;
      end else begin
         if (ctl.last)    major_q <= major_nx;
         if (ctl.ien_clr) ien_q   <= 1'b0;
      end
   end

   assign mem_rd    = ctl.rd;
   assign mem_wr    = ctl.wr;
   assign mem_addr  = mar;
   assign mem_wdata = mbr;
   assign pc_out    = pc;
   assign acc_out   = acc;

endmodule

// File: rtl/uop_sequencer_chk.sv
module uop_sequencer_chk
   import uop_pkg::*;
#(
   parameter int                WORD_W    = 16,
   parameter int                ADDR_W    = 11,
   parameter logic [ADDR_W-1:0] SAVE_ADDR = '0
) (
   input logic              clk,
   input logic              rst_n,
   input logic              mem_rd,
   input logic              mem_wr,
   input logic [ADDR_W-1:0] mem_addr,
   input logic [ADDR_W-1:0] pc_out,
   input logic [WORD_W-1:0] acc_out,
   input major_e            major,
   input logic              ien
);

   a_r11_strobe_excl: assert property (@(posedge clk) disable iff (!rst_n)
      !(mem_rd && mem_wr));

   a_r2_fetch_at_pc: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_rd && major == MC_FETCH) |-> (mem_addr == pc_out));

   a_r2_pc_advance: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_rd && major == MC_FETCH) |=> (pc_out == $past(pc_out) + 1'b1));

   a_r3_acc_exec_only: assert property (@(posedge clk) disable iff (!rst_n)
      (major != MC_EXEC) |=> $stable(acc_out));

   a_r8_save_target: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_wr && major == MC_INTR) |-> (mem_addr == SAVE_ADDR));

   a_r9_disabled_in_int: assert property (@(posedge clk) disable iff (!rst_n)
      (major == MC_INTR) |-> !ien);

   a_r10_halt_frozen: assert property (@(posedge clk) disable iff (!rst_n)
      (major == MC_HALT) |=> (major == MC_HALT && !mem_rd && !mem_wr &&
                              $stable(pc_out) && $stable(acc_out)));

endmodule

bind uop_sequencer uop_sequencer_chk #(
   .WORD_W    (WORD_W),
   .ADDR_W    (ADDR_W),
   .SAVE_ADDR (SAVE_ADDR)
) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .mem_rd   (mem_rd),
   .mem_wr   (mem_wr),
   .mem_addr (mem_addr),
   .pc_out   (pc_out),
   .acc_out  (acc_out),
   .major    (major_q),
   .ien      (ien_q)
);

// File: tb/sim_uop_sequencer.sv
`timescale 1ns/1ps
module sim_uop_sequencer;
   localparam int WORD_W = 16;
   localparam int ADDR_W = 11;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              irq = 1'b1;
   logic              mem_rd, mem_wr;
   logic [ADDR_W-1:0] mem_addr;
   logic [WORD_W-1:0] mem_wdata, mem_rdata;
   logic [ADDR_W-1:0] pc_out;
   logic [WORD_W-1:0] acc_out;

   always #10 clk = ~clk;

   uop_sequencer u0 (
      .clk       (clk),
      .rst_n     (rst_n),
      .irq       (irq),
      .mem_rd    (mem_rd),
      .mem_wr    (mem_wr),
      .mem_addr  (mem_addr),
      .mem_wdata (mem_wdata),
      .mem_rdata (mem_rdata),
      .pc_out    (pc_out),
      .acc_out   (acc_out)
   );

   logic [WORD_W-1:0] mem [0:(1<<ADDR_W)-1];
   always @(posedge clk) if (mem_wr) mem[mem_addr] <= mem_wdata;
   assign mem_rdata = mem_rd ? mem[mem_addr] : '0;

   typedef struct {
      int    cyc;
      bit    wr;
      int    addr;
      int    data;
      string tag;
   } txn_t;

   txn_t exp_q[$];
   int   cyc = 0;
   int   n_checks = 0;
   int   n_errors = 0;
   bit   running = 1'b0;

   always @(posedge clk) if (rst_n) cyc <= cyc + 1;

   task automatic check(input bit ok, input string tag, input int act, input int exp);
      n_checks++;
      if (!ok) begin
         n_errors++;
         $display("FAIL %s: actual %0d (0x%0h), expected %0d (0x%0h)", tag, act, act, exp, exp);
      end
   endtask

   task automatic push_exp(input int c, input bit w, input int a, input int d, input string tag);
      txn_t t;
      t.cyc = c; t.wr = w; t.addr = a; t.data = d; t.tag = tag;
      exp_q.push_back(t);
   endtask

   // monitor: compares each bus transaction with the scoreboard, plus timed register checks
   always @(negedge clk) begin
      if (running) begin
         if (mem_rd || mem_wr) begin
            if (exp_q.size() == 0) begin
               check(1'b0, "R10 unexpected strobe after halt", int'(mem_addr), -1);
            end else begin
               txn_t t;
               t = exp_q.pop_front();
               check(cyc == t.cyc, {t.tag, " cycle"}, cyc, t.cyc);
               check(mem_wr == t.wr, {t.tag, " direction"}, int'(mem_wr), int'(t.wr));
               check(int'(mem_addr) == t.addr, {t.tag, " address"}, int'(mem_addr), t.addr);
               if (t.wr) check(int'(mem_wdata) == t.data, {t.tag, " write data"}, int'(mem_wdata), t.data);
               else      check(int'(mem_rdata) == t.data, {t.tag, " read data"}, int'(mem_rdata), t.data);
            end
         end
         case (cyc)
            6:  check(acc_out == 16'd5,  "R3 acc after first add", int'(acc_out), 5);
            9:  check(pc_out == 11'd1,   "R8 pc at routine address", int'(pc_out), 1);
            15: check(pc_out == 11'd31,  "R7 pc at X+1", int'(pc_out), 31);
            24: check(acc_out == 16'd12, "R4 acc after indirect add", int'(acc_out), 12);
            31: check(pc_out == 11'd34,  "R5 pc after skip", int'(pc_out), 34);
            38: check(pc_out == 11'd35,  "R6 pc without skip", int'(pc_out), 35);
            default: ;
         endcase
      end
   end

   initial begin
      for (int i = 0; i < (1<<ADDR_W); i++) mem[i] = '0;
      // program: [15:12] opcode (0 add, 1 isz, 2 bsa, 15 halt), [11] indirect, [10:0] address
      mem[0]  = 16'h000A;            // add 10 (overwritten by interrupt save)
      mem[1]  = 16'h201E;            // bsa 30
      mem[31] = 16'h080B;            // add indirect via 11
      mem[32] = 16'h100D;            // isz 13 (wraps to zero -> skip)
      mem[33] = 16'hF000;            // halt, must be skipped
      mem[34] = 16'h100E;            // isz 14 (no skip)
      mem[35] = 16'h000A;            // add 10
      mem[36] = 16'hF000;            // halt
      mem[10] = 16'd5;
      mem[11] = 16'd12;
      mem[12] = 16'd7;
      mem[13] = 16'hFFFF;
      mem[14] = 16'd3;

      push_exp(1,  0, 0,  16'h000A, "R2 fetch add");
      push_exp(4,  0, 10, 5,        "R3 add operand");
      push_exp(8,  1, 0,  1,        "R8 interrupt save");
      push_exp(10, 0, 1,  16'h201E, "R2 fetch bsa");
      push_exp(13, 1, 30, 2,        "R7 return link");
      push_exp(16, 0, 31, 16'h080B, "R7 resume at X+1");
      push_exp(19, 0, 11, 12,       "R4 pointer read");
      push_exp(22, 0, 12, 7,        "R4 operand via pointer");
      push_exp(25, 0, 32, 16'h100D, "R2 fetch isz");
      push_exp(28, 0, 13, 16'hFFFF, "R5 isz read");
      push_exp(30, 1, 13, 0,        "R5 isz write zero");
      push_exp(32, 0, 34, 16'h100E, "R5 skip lands past halt");
      push_exp(35, 0, 14, 3,        "R6 isz read");
      push_exp(37, 1, 14, 4,        "R6 isz write");
      push_exp(39, 0, 35, 16'h000A, "R9 irq ignored when disabled");
      push_exp(42, 0, 10, 5,        "R3 add operand again");
      push_exp(45, 0, 36, 16'hF000, "R10 fetch halt");

      repeat (3) @(negedge clk);
      check(pc_out == '0,  "R1 reset pc", int'(pc_out), 0);
      check(acc_out == '0, "R1 reset acc", int'(acc_out), 0);
      check(!mem_rd && !mem_wr, "R1 strobes low in reset", int'({mem_rd, mem_wr}), 0);
      rst_n = 1'b1;
      check(!mem_rd && !mem_wr, "R1 no strobe in fetch t1", int'({mem_rd, mem_wr}), 0);
      running = 1'b1;

      while (exp_q.size() != 0 && cyc < 2000) @(negedge clk);
      if (cyc >= 2000) check(1'b0, "watchdog expired", cyc, 2000);
      repeat (40) @(negedge clk);
      check(exp_q.size() == 0, "R10 all transactions seen", exp_q.size(), 0);
      check(pc_out == 11'd37,  "R10 pc frozen after halt", int'(pc_out), 37);
      check(acc_out == 16'd17, "R3 final accumulator", int'(acc_out), 17);
      check(mem[0] == 16'd1,   "R8 saved return pc", int'(mem[0]), 1);
      check(mem[13] == 16'd0,  "R5 memory after wrap", int'(mem[13]), 0);
      check(mem[14] == 16'd4,  "R6 memory after increment", int'(mem[14]), 4);
      check(mem[30] == 16'd2,  "R7 link word", int'(mem[30]), 2);
      running = 1'b0;
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
      $finish;
   end

   // R11 is also watched here: both strobes high counts as a failure
   always @(negedge clk) if (running && mem_rd && mem_wr)
      check(1'b0, "R11 both strobes high", 3, 0);

endmodule